// File: doc/BRIEF.md
# Programmable event-to-task interconnect

This block links peripherals to each other without a processor in the loop. Each input bit of `evt_i` is a single-cycle event pulse from some peripheral, and each output bit of `task_o` is a single-cycle task pulse to some peripheral. A number of channels sit between them. Each channel holds three selectors: one event selector, one primary task selector and one fork task selector. When an enabled channel sees its selected event, it pulses both of its selected targets on the next clock cycle.

Channels can be switched on and off in three ways. Software can write the enable word directly, or write a mask to a set alias or a clear alias. Channels can also be gathered into groups, each with a membership mask. Every group has an enable trigger and a disable trigger. Software can fire these triggers through the register port. A channel can also select a group trigger as one of its task targets, so sets of channels can be switched at run time from hardware events.

The register port is word-addressed. Writes take effect on the clock edge. Reads are combinational on the same address.

Top module: `evt_xbar`

## Requirements
- R1: After reset, the enable word (address 0x00) and every group mask (0x08+g) read 0. Every selector (event 0x20+c, task 0x40+c, fork 0x60+c) reads 0xFF, which is out of range. `task_o` is 0.
- R2: Writing to address 0x01 sets every enable bit whose data bit is 1 and leaves the others unchanged. Writing to 0x00 replaces the enable word.
- R3: Writing to address 0x02 clears every enable bit whose data bit is 1 and leaves the others unchanged.
- R4: An enabled channel whose event selector value e has `evt_i[e]` high in cycle t drives a task pulse on the output given by its task selector in cycle t+1, for exactly one cycle. A disabled channel drives nothing.
- R5: The same event also pulses the output given by the channel's fork selector in the same cycle as the primary task.
- R6: When several channels target the same output in one cycle, their pulses are ORed into a single pulse.
- R7: An event selector at or above the number of event inputs routes nothing. A task or fork selector at or above N_TSK+2*N_GRP routes nothing.
- R8: Group mask g sits at 0x08+g and reads back what was written; bit n includes channel n. Writing 0 empties the group.
- R9: Writing a value with bit 0 set to 0x10+g (enable trigger of group g) sets the enable bits of the group's members. Doing the same to 0x18+g (disable trigger) clears them. Non-members are unchanged.
- R10: Task selector value N_TSK+2g fires the enable trigger of group g, and N_TSK+2g+1 fires its disable trigger. The members' enable bits change at the same edge where a plain task pulse would be registered. `task_o` shows no pulse for these targets.
- R11: A group trigger overrides a register write to the same enable bit in the same cycle. If an enable trigger and a disable trigger reach the same bit together, the disable wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Word address for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| evt_i | input | N_EVT | Event pulses |
| task_o | output | N_TSK | Task pulses, registered |

## Verification
Two things can happen in the same cycle and compete for one enable bit: a register write through the set, clear or direct alias, and a group trigger fired by a channel whose event is arriving at that moment. The bench provokes this in two ways. It writes a clear alias in the very cycle a channel fires a group enable trigger. It also lets one channel fire both the enable trigger and the disable trigger of the same group. The enable word is then read back and compared with a bench model that applies the write first and the group result on top. Random mixes of writes, group triggers and events keep hitting these collisions, and every cycle is judged against the same model.

// File: rtl/evx_pkg.sv
package evx_pkg;
  localparam int ADDR_W = 8;
  localparam int DW     = 32;
  localparam int SEL_W  = 8;

  localparam logic [ADDR_W-1:0] A_EN    = 8'h00;
  localparam logic [ADDR_W-1:0] A_SET   = 8'h01;
  localparam logic [ADDR_W-1:0] A_CLR   = 8'h02;
  localparam logic [ADDR_W-1:0] A_GMASK = 8'h08;
  localparam logic [ADDR_W-1:0] A_GEN   = 8'h10;
  localparam logic [ADDR_W-1:0] A_GDIS  = 8'h18;
  localparam logic [ADDR_W-1:0] A_ESEL  = 8'h20;
  localparam logic [ADDR_W-1:0] A_TSEL  = 8'h40;
  localparam logic [ADDR_W-1:0] A_FSEL  = 8'h60;

  function automatic logic [ADDR_W-1:0] aoff(logic [ADDR_W-1:0] base, int idx);
    return base + ADDR_W'(idx);
  endfunction
endpackage

// File: rtl/evx_regs.sv
module evx_regs import evx_pkg::*; #(
  parameter int N_CH  = 8,
  parameter int N_GRP = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DW-1:0]                 wdata_i,
  output logic [DW-1:0]                 rdata_o,
  input  logic [N_GRP-1:0]              hw_gen_i,
  input  logic [N_GRP-1:0]              hw_gdis_i,
  output logic [N_CH-1:0]               en_o,
  output logic [N_CH-1:0][SEL_W-1:0]    esel_o,
  output logic [N_CH-1:0][SEL_W-1:0]    tsel_o,
  output logic [N_CH-1:0][SEL_W-1:0]    fsel_o,
  output logic [N_CH-1:0]               grp_set_o,
  output logic [N_CH-1:0]               grp_clr_o
);
  logic [N_CH-1:0]             en_q, en_d, wmask;
  logic [N_GRP-1:0][N_CH-1:0]  gmask_q;
  logic [N_CH-1:0][SEL_W-1:0]  esel_q, tsel_q, fsel_q;
  logic                        unused_wdata;

  assign wmask        = wdata_i[N_CH-1:0];
  assign unused_wdata = ^wdata_i;

  // group triggers act on the masks as they stand this cycle
  always_comb begin
    grp_set_o = '0;
    grp_clr_o = '0;
    for (int g = 0; g < N_GRP; g++) begin
      if (hw_gen_i[g] || (we_i && addr_i == aoff(A_GEN, g) && wdata_i[0]))
        grp_set_o = grp_set_o | gmask_q[g];
      if (hw_gdis_i[g] || (we_i && addr_i == aoff(A_GDIS, g) && wdata_i[0]))
        grp_clr_o = grp_clr_o | gmask_q[g];
    end
  end

  // register write first, group result on top, disable last
  always_comb begin
    en_d = en_q;
    if (we_i) begin
      if (addr_i == A_EN)  en_d = wmask;
      if (addr_i == A_SET) en_d = en_q | wmask;
      if (addr_i == A_CLR) en_d = en_q & ~wmask;
    end
    en_d = (en_d | grp_set_o) & ~grp_clr_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gmask_q <= '0;
    end else if (we_i) begin
      for (int g = 0; g < N_GRP; g++)
        if (addr_i == aoff(A_GMASK, g)) gmask_q[g] <= wmask;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      esel_q <= '1;
      tsel_q <= '1;
      fsel_q <= '1;
    end else if (we_i) begin
      for (int c = 0; c < N_CH; c++) begin
        if (addr_i == aoff(A_ESEL, c)) esel_q[c] <= wdata_i[SEL_W-1:0];
        if (addr_i == aoff(A_TSEL, c)) tsel_q[c] <= wdata_i[SEL_W-1:0];
        if (addr_i == aoff(A_FSEL, c)) fsel_q[c] <= wdata_i[SEL_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_EN) rdata_o[N_CH-1:0] = en_q;
    for (int g = 0; g < N_GRP; g++)
      if (addr_i == aoff(A_GMASK, g)) rdata_o[N_CH-1:0] = gmask_q[g];
    for (int c = 0; c < N_CH; c++) begin
      if (addr_i == aoff(A_ESEL, c)) rdata_o[SEL_W-1:0] = esel_q[c];
      if (addr_i == aoff(A_TSEL, c)) rdata_o[SEL_W-1:0] = tsel_q[c];
      if (addr_i == aoff(A_FSEL, c)) rdata_o[SEL_W-1:0] = fsel_q[c];
    end
  end

  assign en_o   = en_q;
  assign esel_o = esel_q;
  assign tsel_o = tsel_q;
  assign fsel_o = fsel_q;
endmodule

// File: rtl/evx_route.sv
module evx_route import evx_pkg::*; #(
  parameter int N_CH  = 8,
  parameter int N_EVT = 8,
  parameter int N_TGT = 16
) (
  input  logic [N_CH-1:0]             en_i,
  input  logic [N_EVT-1:0]            evt_i,
  input  logic [N_CH-1:0][SEL_W-1:0]  esel_i,
  input  logic [N_CH-1:0][SEL_W-1:0]  tsel_i,
  input  logic [N_CH-1:0][SEL_W-1:0]  fsel_i,
  output logic [N_TGT-1:0]            tgt_o
);
  logic [N_CH-1:0] fire;

  for (genvar c = 0; c < N_CH; c++) begin : g_fire
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int e = 0; e < N_EVT; e++)
        if (esel_i[c] == SEL_W'(e)) hit = evt_i[e];
    end
    assign fire[c] = en_i[c] & hit;
  end

  always_comb begin
    tgt_o = '0;
    for (int c = 0; c < N_CH; c++)
      for (int t = 0; t < N_TGT; t++)
        if (fire[c] && (tsel_i[c] == SEL_W'(t) || fsel_i[c] == SEL_W'(t)))
          tgt_o[t] = 1'b1;
  end
endmodule

// File: rtl/evt_xbar.sv
module evt_xbar import evx_pkg::*; #(
  parameter int N_CH  = 8,
  parameter int N_EVT = 8,
  parameter int N_TSK = 8,
  parameter int N_GRP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic [N_EVT-1:0]  evt_i,
  output logic [N_TSK-1:0]  task_o
);
  localparam int N_TGT = N_TSK + 2 * N_GRP;

  logic [N_CH-1:0]            en_q, grp_set, grp_clr;
  logic [N_CH-1:0][SEL_W-1:0] esel, tsel, fsel;
  logic [N_TGT-1:0]           tgt;
  logic [N_GRP-1:0]           hw_gen, hw_gdis;
  logic [N_TSK-1:0]           task_q;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign hw_gen[g]  = tgt[N_TSK + 2*g];
    assign hw_gdis[g] = tgt[N_TSK + 2*g + 1];
  end

  evx_regs #(.N_CH(N_CH), .N_GRP(N_GRP)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .hw_gen_i  (hw_gen),
    .hw_gdis_i (hw_gdis),
    .en_o      (en_q),
    .esel_o    (esel),
    .tsel_o    (tsel),
    .fsel_o    (fsel),
    .grp_set_o (grp_set),
    .grp_clr_o (grp_clr)
  );

  evx_route #(.N_CH(N_CH), .N_EVT(N_EVT), .N_TGT(N_TGT)) i_route (
    .en_i   (en_q),
    .evt_i  (evt_i),
    .esel_i (esel),
    .tsel_i (tsel),
    .fsel_i (fsel),
    .tgt_o  (tgt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) task_q <= '0;
    else         task_q <= tgt[N_TSK-1:0];
  end

  assign task_o = task_q;
endmodule

// File: rtl/evx_chk.sv
module evx_chk import evx_pkg::*; #(
  parameter int N_CH  = 8,
  parameter int N_TSK = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [N_CH-1:0]   en_i,
  input logic [N_CH-1:0]   grp_set_i,
  input logic [N_CH-1:0]   grp_clr_i,
  input logic [N_TSK-1:0]  task_i
);
  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_SET && grp_clr_i == '0) |=>
      ((en_i & $past(wdata_i[N_CH-1:0])) == $past(wdata_i[N_CH-1:0])))
    else $error("set alias lost a bit");

  p_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CLR && grp_set_i == '0) |=>
      ((en_i & $past(wdata_i[N_CH-1:0])) == '0))
    else $error("clear alias left a bit");

  p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |=> (task_i == '0))
    else $error("task pulse with no channel enabled");

  p_grp_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grp_set_i & ~grp_clr_i) != '0) |=>
      ((en_i & $past(grp_set_i & ~grp_clr_i)) == $past(grp_set_i & ~grp_clr_i)))
    else $error("group enable did not set members");

  p_grp_pri_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_clr_i != '0) |=> ((en_i & $past(grp_clr_i)) == '0))
    else $error("group disable lost priority");
endmodule

bind evt_xbar evx_chk #(.N_CH(N_CH), .N_TSK(N_TSK)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (reg_we_i),
  .addr_i    (reg_addr_i),
  .wdata_i   (reg_wdata_i),
  .en_i      (en_q),
  .grp_set_i (grp_set),
  .grp_clr_i (grp_clr),
  .task_i    (task_o)
);

// File: tb/test_evt_xbar.sv
module test_evt_xbar;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic [7:0]  evt = '0;
  logic [7:0]  task_w;

  int n_cmp = 0;
  int n_bad = 0;

  // model state: 8 channels, 8 events, 8 tasks, 4 groups
  logic [7:0] en_m;
  logic [7:0] gm_m [4];
  logic [7:0] es_m [8];
  logic [7:0] ts_m [8];
  logic [7:0] fs_m [8];

  always #5 clk = ~clk;

  evt_xbar i_evt_xbar (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wd),
    .reg_rdata_o (rdata),
    .evt_i       (evt),
    .task_o      (task_w)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic void predict(input logic w, input logic [7:0] a, input logic [31:0] d,
                                  input logic [7:0] ev, output logic [7:0] xt,
                                  output logic [7:0] xen);
    logic [15:0] tg = '0;
    logic [7:0]  gs = '0, gc = '0, e2;
    for (int c = 0; c < 8; c++)
      if (en_m[c] && es_m[c] < 8 && ev[es_m[c][2:0]]) begin
        if (ts_m[c] < 16) tg[ts_m[c][3:0]] = 1'b1;
        if (fs_m[c] < 16) tg[fs_m[c][3:0]] = 1'b1;
      end
    for (int g = 0; g < 4; g++) begin
      if (tg[8+2*g]   || (w && a == 8'h10 + 8'(g) && d[0])) gs = gs | gm_m[g];
      if (tg[8+2*g+1] || (w && a == 8'h18 + 8'(g) && d[0])) gc = gc | gm_m[g];
    end
    e2 = en_m;
    if (w && a == 8'h00) e2 = d[7:0];
    if (w && a == 8'h01) e2 = en_m | d[7:0];
    if (w && a == 8'h02) e2 = en_m & ~d[7:0];
    xen = (e2 | gs) & ~gc;
    xt  = tg[7:0];
  endfunction

  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic [7:0] ev, input string req);
    logic [7:0] xt, xen;
    @(negedge clk);
    we = w; addr = a; wd = d; evt = ev;
    predict(w, a, d, ev, xt, xen);
    @(posedge clk);
    #1;
    chk({24'h0, task_w}, {24'h0, xt}, req);
    en_m = xen;
    if (w) begin
      if (a >= 8'h08 && a < 8'h0C) gm_m[a-8'h08] = d[7:0];
      if (a >= 8'h20 && a < 8'h28) es_m[a-8'h20] = d[7:0];
      if (a >= 8'h40 && a < 8'h48) ts_m[a-8'h40] = d[7:0];
      if (a >= 8'h60 && a < 8'h68) fs_m[a-8'h60] = d[7:0];
    end
    we = 1'b0; evt = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    step(1'b1, a, d, 8'h00, req);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    chk(rdata, exp, req);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    en_m = '0;
    for (int g = 0; g < 4; g++) gm_m[g] = '0;
    for (int c = 0; c < 8; c++) begin es_m[c] = 8'hFF; ts_m[c] = 8'hFF; fs_m[c] = 8'hFF; end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(8'h00, 32'h0, "R1 enable");
    rd_chk(8'h09, 32'h0, "R1 group mask");
    rd_chk(8'h23, 32'hFF, "R1 event selector");
    rd_chk(8'h45, 32'hFF, "R1 task selector");
    chk({24'h0, task_w}, 32'h0, "R1 task_o");

    // R2 / R3 aliases
    wr(8'h01, 32'h0F, "R2");
    rd_chk(8'h00, 32'h0F, "R2 set");
    wr(8'h01, 32'h30, "R2");
    rd_chk(8'h00, 32'h3F, "R2 zero bits unchanged");
    wr(8'h02, 32'h05, "R3");
    rd_chk(8'h00, 32'h3A, "R3 clear");
    wr(8'h00, 32'h3A, "R2");
    rd_chk(8'h00, 32'h3A, "R2 direct write");

    // R4 basic routing: ch0 evt3 -> task2
    wr(8'h20, 32'h03, "R4"); wr(8'h40, 32'h02, "R4");
    wr(8'h01, 32'h01, "R4");
    step(1'b0, 8'h00, 0, 8'h08, "R4 pulse");
    chk({24'h0, task_w}, 32'h04, "R4 pulse value");
    step(1'b0, 8'h00, 0, 8'h00, "R4 single cycle");
    chk({24'h0, task_w}, 32'h00, "R4 pulse ended");
    // disabled ch2 evt4 -> task5
    wr(8'h22, 32'h04, "R4"); wr(8'h42, 32'h05, "R4");
    step(1'b0, 8'h00, 0, 8'h10, "R4 disabled channel");
    chk({24'h0, task_w}, 32'h00, "R4 disabled silent");

    // R5 fork
    wr(8'h60, 32'h06, "R5");
    step(1'b0, 8'h00, 0, 8'h08, "R5 fork");
    chk({24'h0, task_w}, 32'h44, "R5 fork value");

    // R6 OR merge: ch1 evt5 -> task2
    wr(8'h21, 32'h05, "R6"); wr(8'h41, 32'h02, "R6");
    step(1'b0, 8'h00, 0, 8'h28, "R6 merge");
    chk({24'h0, task_w}, 32'h44, "R6 merged value");
    step(1'b0, 8'h00, 0, 8'h20, "R6 single source");
    chk({24'h0, task_w}, 32'h04, "R6 single value");

    // R7 out-of-range selectors
    wr(8'h23, 32'h09, "R7"); wr(8'h43, 32'h01, "R7");
    wr(8'h24, 32'h00, "R7"); wr(8'h44, 32'h14, "R7");
    step(1'b0, 8'h00, 0, 8'h01, "R7 task out of range");
    chk({24'h0, task_w}, 32'h00, "R7 nothing routed");
    step(1'b0, 8'h00, 0, 8'h80, "R7 event out of range");
    chk({24'h0, task_w}, 32'h00, "R7 nothing routed ev");
    rd_chk(8'h00, {24'h0, en_m}, "R7 enable untouched");

    // R8 group masks
    wr(8'h08, 32'h0C, "R8"); wr(8'h09, 32'h03, "R8");
    rd_chk(8'h08, 32'h0C, "R8 readback");
    wr(8'h0A, 32'h80, "R8"); wr(8'h0A, 32'h00, "R8");
    rd_chk(8'h0A, 32'h00, "R8 emptied");

    // R9 software group triggers
    wr(8'h11, 32'h1, "R9");
    rd_chk(8'h00, 32'h3B, "R9 group enable");
    wr(8'h18, 32'h1, "R9");
    rd_chk(8'h00, 32'h33, "R9 group disable");
    wr(8'h19, 32'h0, "R9");
    rd_chk(8'h00, 32'h33, "R9 bit0 clear no trigger");

    // R10 channel fires group 0 enable: ch5 evt6 -> target 8
    wr(8'h25, 32'h06, "R10"); wr(8'h45, 32'h08, "R10");
    step(1'b0, 8'h00, 0, 8'h40, "R10 no task pulse");
    rd_chk(8'h00, 32'h3F, "R10 group enabled by channel");

    // R11 priority: clear write vs group enable in same cycle
    step(1'b1, 8'h02, 32'h0C, 8'h40, "R11");
    rd_chk(8'h00, 32'h3F, "R11 group beats write");
    // enable and disable of group 0 together
    wr(8'h65, 32'h09, "R11");
    step(1'b0, 8'h00, 0, 8'h40, "R11");
    rd_chk(8'h00, 32'h33, "R11 disable wins");

    // random phase
    for (int i = 0; i < 400; i++) begin
      int k;
      int g;
      int c;
      logic [7:0]  a;
      logic [31:0] d;
      logic        w;
      k = $urandom_range(0, 11);
      g = $urandom_range(0, 3);
      c = $urandom_range(0, 7);
      w = 1'b1;
      d = $urandom;
      case (k)
        0: a = 8'h01;
        1: a = 8'h02;
        2: a = 8'h00;
        3: a = 8'h08 + 8'(g);
        4: begin a = 8'h10 + 8'(g); d = 32'h1; end
        5: begin a = 8'h18 + 8'(g); d = 32'h1; end
        6: begin a = 8'h20 + 8'(c); d = $urandom_range(0, 9); end
        7: begin a = 8'h40 + 8'(c); d = $urandom_range(0, 17); end
        8: begin a = 8'h60 + 8'(c); d = $urandom_range(0, 17); end
        default: begin a = 8'h00; w = 1'b0; end
      endcase
      step(w, a, d, 8'($urandom), "R6 random routing");
      if (i % 8 == 7) rd_chk(8'h00, {24'h0, en_m}, "R11 random enable");
      if (i % 32 == 31) rd_chk(8'h08 + 8'(g), {24'h0, gm_m[g]}, "R8 random mask");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule